// File: doc/BRIEF.md
# Serial Configuration Slave for a Clock Generator

This block is the control port of a system clock generator. A host reaches it over a two-wire serial bus (start and stop conditions, 8-bit bytes, ninth-bit acknowledge, standard-mode rates). The block holds six configuration bytes. Byte 0 carries the frequency code, the choice between that code and the board straps, the spread-spectrum profile and enable, and a global tristate bit. Bytes 1 to 5 hold per-output enable bits, and the clock logic downstream reads them directly.

Access always runs in order. A write names the device, then sends a command byte and a count byte, and the block acknowledges both and discards them. The data bytes that follow land in byte 0, then byte 1, and so on, until the host sends a stop. A read returns a count and then bytes 0 to 5. The three frequency straps and the mode strap are captured while reset is held. They stay fixed after that, and the effective frequency code is either this captured value or the register field.

The bus is sampled by the system clock through synchronizers. The data line is driven only low, through an output-enable.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: The 8-bit device byte 0xD2 (7-bit address 0x69 followed by a write bit of 0) and 0xD3 (read bit of 1) are acknowledged by pulling SDA low in the ninth clock. Any other device byte gets no acknowledge, and the block stays off the bus until the next start.
- R2: In a write, the block acknowledges the first two bytes after the device byte and stores neither. The third byte goes to config byte 0, the fourth to byte 1, and so on in order. At most one byte is written per system clock.
- R3: A stop after a complete byte keeps every byte already written and leaves later bytes unchanged. A byte cut short by a stop is dropped.
- R4: A read returns 0x06 first, then config bytes 0 to 5 in order, then 0xFF for any further byte. The read ends when the host answers a byte with no acknowledge.
- R5: After reset, byte 0 is 0x10 and bytes 1 to 5 are 0xFF.
- R6: When byte 0 bit 3 is 0, `freq_code` equals the captured frequency straps. When bit 3 is 1, `freq_code` equals byte 0 bits 6:4. `freq_override` shows bit 3.
- R7: `spread_en` is byte 0 bit 1. `out_tristate` is byte 0 bit 0. `spread_prof` is {bit 7, bit 2}, with 00 = ±0.25 % center, 01 = ±0.15 % center, 10 = 0 to −0.5 % down and 11 = ±0.375 % center. `out_en` is bytes 5..1 concatenated, with byte 1 in bits 7:0.
- R8: `strap_fs` and `strap_mode` are captured on every clock while `rst_n` is low and hold their values once it is high.
- R9: Data bytes past byte 5 in a write are acknowledged and change nothing.
- R10: The block changes its SDA drive only while SCL is low, and it does not drive SDA after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus bit rate |
| rst_n | input | 1 | Active-low reset; straps are captured while it is low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 = pull SDA low |
| strap_fs | input | 3 | Frequency-select straps |
| strap_mode | input | 1 | Mode strap |
| freq_code | output | 3 | Effective frequency code |
| freq_override | output | 1 | 1 = code taken from the register |
| spread_en | output | 1 | Spread spectrum enabled |
| spread_prof | output | 2 | Spread profile code |
| out_tristate | output | 1 | Tristate all clock outputs |
| out_en | output | 40 | Per-output enables, bytes 5..1 |
| mode_latched | output | 1 | Captured mode strap |

## Verification
The bench builds the block with its default parameters: bus address 0x69, six config bytes and two synchronizer stages. With these defaults the bench can reach a write that runs past the last byte, and a read that runs past it too, at ordinary bus lengths. The 20-clock SCL half period leaves a few clocks of slack beyond the synchronizer and edge-detect latency. This lets the ack sampling and the check that SDA moves only while SCL is low be exercised with a realistic margin.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } bus_state_t;

    localparam logic [7:0] BYTE0_RESET = 8'h10;
    localparam logic [7:0] ENABLE_RESET = 8'hFF;
    localparam logic [7:0] PAST_END_READ = 8'hFF;
endpackage

// File: rtl/clkcfg_bus_sampler.sv
module clkcfg_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_prev;
    logic              sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q    <= '1;
            sda_q    <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_q    <= {scl_q[STAGES-2:0], scl_i};
            sda_q    <= {sda_q[STAGES-2:0], sda_i};
            scl_prev <= scl_q[STAGES-1];
            sda_prev <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s && !scl_prev;
    assign scl_fall  = !scl_s && scl_prev;
    assign start_det = scl_s && scl_prev && sda_prev && !sda_s;
    assign stop_det  = scl_s && scl_prev && !sda_prev && sda_s;
endmodule

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         NUM_BYTES = 6,
    localparam int        IDX_W     = $clog2(NUM_BYTES + 3) + 1,
    localparam int        IMG_W     = 8 * NUM_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sda_s,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic [IMG_W-1:0]     rd_bytes,
    output logic                 sda_oe,
    output logic [NUM_BYTES-1:0] wr_sel,
    output logic [7:0]           wr_data
);
    bus_state_t        state, state_nx;
    logic [7:0]        shreg;
    logic [3:0]        bitcnt;
    logic [IDX_W-1:0]  byte_idx;
    logic              rd_dir;
    logic [7:0]        rd_byte;
    logic              wr_fire;
    logic              addr_hit;

    assign addr_hit = (shreg[7:1] == DEV_ADDR);

    // byte source for reads: count, then image, then filler
    always_comb begin
        rd_byte = PAST_END_READ;
        if (byte_idx == '0) begin
            rd_byte = 8'(NUM_BYTES);
        end
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (int'(byte_idx) == k + 1) begin
                rd_byte = rd_bytes[k*8 +: 8];
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (scl_fall && bitcnt == 4'd8)
                                 state_nx = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall)
                                 state_nx = rd_dir ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && bitcnt == 4'd8)
                                 state_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall)
                                 state_nx = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bitcnt == 4'd7)
                                 state_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_rise && sda_s)
                                 state_nx = ST_IDLE;
                             else if (scl_fall)
                                 state_nx = ST_RD_BYTE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bitcnt   <= '0;
            byte_idx <= '0;
            rd_dir   <= 1'b0;
        end else if (start_det) begin
            bitcnt   <= '0;
            byte_idx <= '0;
        end else if (!stop_det) begin
            unique case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (scl_fall && bitcnt == 4'd8) begin
                        if (state == ST_ADDR) rd_dir <= shreg[0];
                        else if (byte_idx != '1) byte_idx <= byte_idx + 1'b1;
                    end
                end
                ST_ADDR_ACK, ST_RD_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (rd_dir) begin
                            shreg <= rd_byte;
                            if (byte_idx != '1) byte_idx <= byte_idx + 1'b1;
                        end
                    end
                end
                ST_WR_ACK: if (scl_fall) bitcnt <= '0;
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        shreg  <= {shreg[6:0], 1'b1};
                        bitcnt <= bitcnt + 4'd1;
                    end
                end
                ST_IDLE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = !shreg[7];
            default:                sda_oe = 1'b0;
        endcase
    end

    assign wr_fire = (state == ST_WR_BYTE) && scl_fall && (bitcnt == 4'd8)
                     && !start_det && !stop_det;
    assign wr_data = shreg;

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_sel
        assign wr_sel[g] = wr_fire && (int'(byte_idx) == g + 2);
    end
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
    import clkcfg_pkg::*;
#(
    parameter int  NUM_BYTES = 6,
    localparam int IMG_W     = 8 * NUM_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BYTES-1:0] wr_sel,
    input  logic [7:0]           wr_data,
    output logic [IMG_W-1:0]     image
);
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        localparam logic [7:0] RST_VAL = (g == 0) ? BYTE0_RESET : ENABLE_RESET;
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= RST_VAL;
            else if (wr_sel[g]) q <= wr_data;
        end
        assign image[g*8 +: 8] = q;
    end
endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_BYTES   = 6,
    parameter int         SYNC_STAGES = 2,
    localparam int        IMG_W       = 8 * NUM_BYTES,
    localparam int        EN_W        = 8 * (NUM_BYTES - 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe,
    input  logic [2:0]      strap_fs,
    input  logic            strap_mode,
    output logic [2:0]      freq_code,
    output logic            freq_override,
    output logic            spread_en,
    output logic [1:0]      spread_prof,
    output logic            out_tristate,
    output logic [EN_W-1:0] out_en,
    output logic            mode_latched
);
    logic                 scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [NUM_BYTES-1:0] wr_sel;
    logic [7:0]           wr_data;
    logic [IMG_W-1:0]     cfg_flat;
    logic [2:0]           fs_latched;

    clkcfg_bus_sampler #(.STAGES(SYNC_STAGES)) u_samp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    clkcfg_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_BYTES(NUM_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_bytes(cfg_flat), .sda_oe(sda_oe), .wr_sel(wr_sel), .wr_data(wr_data)
    );

    clkcfg_regs #(.NUM_BYTES(NUM_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(wr_data),
        .image(cfg_flat)
    );

    // straps follow the pins while reset is held, then freeze
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_latched   <= strap_fs;
            mode_latched <= strap_mode;
        end
    end

    assign freq_override = cfg_flat[3];
    assign freq_code     = cfg_flat[3] ? cfg_flat[6:4] : fs_latched;
    assign spread_en     = cfg_flat[1];
    assign spread_prof   = {cfg_flat[7], cfg_flat[2]};
    assign out_tristate  = cfg_flat[0];
    assign out_en        = cfg_flat[IMG_W-1:8];
endmodule

// File: rtl/clkcfg_chk.sv
module clkcfg_chk #(
    parameter int  NUM_BYTES = 6,
    localparam int IMG_W     = 8 * NUM_BYTES
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sda_oe,
    input logic                 scl_s,
    input logic                 stop_det,
    input logic [NUM_BYTES-1:0] wr_sel,
    input logic [IMG_W-1:0]     cfg_flat,
    input logic [2:0]           fs_latched,
    input logic                 mode_latched
);
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s); // R10
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R10
    AST_ONE_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel)); // R2
    AST_IMAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel == '0) |=> $stable(cfg_flat)); // R3
    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable({fs_latched, mode_latched})); // R8
endmodule

bind clkcfg_serial_slave clkcfg_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
    .stop_det(stop_det), .wr_sel(wr_sel), .cfg_flat(cfg_flat),
    .fs_latched(fs_latched), .mode_latched(mode_latched)
);

// File: tb/sim_clkcfg_serial_slave.sv
module sim_clkcfg_serial_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_scl = 1'b1;
    logic host_sda = 1'b1;
    logic sda_oe;
    logic [2:0] strap_fs = 3'b101;
    logic strap_mode = 1'b1;
    logic [2:0] freq_code;
    logic freq_override, spread_en, out_tristate, mode_latched;
    logic [1:0] spread_prof;
    logic [39:0] out_en;
    wire sda_line = host_sda & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit quiet = 1'b0;
    bit done = 1'b0;

    logic [7:0] m_reg [6];
    logic [2:0] m_strap;
    logic m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkcfg_serial_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_fs(strap_fs), .strap_mode(strap_mode),
        .freq_code(freq_code), .freq_override(freq_override),
        .spread_en(spread_en), .spread_prof(spread_prof),
        .out_tristate(out_tristate), .out_en(out_en), .mode_latched(mode_latched)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock reference comparison while the bus is quiet (R5 R6 R7 R8)
    always @(negedge clk) begin
        if (quiet && !done) begin
            logic [2:0] ef;
            ef = m_reg[0][3] ? m_reg[0][6:4] : m_strap;
            chk("R6_R7 model compare",
                {freq_code, freq_override, spread_en, spread_prof, out_tristate, out_en, mode_latched},
                {ef, m_reg[0][3], m_reg[0][1], m_reg[0][7], m_reg[0][2], m_reg[0][0],
                 m_reg[5], m_reg[4], m_reg[3], m_reg[2], m_reg[1], m_mode});
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        quiet = 1'b0;
        host_sda = 1'b1; host_scl = 1'b1; wq(Q);
        host_sda = 1'b0; wq(Q);
        host_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wq(Q);
        host_scl = 1'b1; wq(Q);
        host_sda = 1'b1; wq(2*Q);
        chk("R10 released after stop", sda_oe, 0);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            host_sda = b[i]; wq(Q);
            host_scl = 1'b1; wq(2*Q);
            host_scl = 1'b0; wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        host_sda = 1'b1; wq(Q);
        host_scl = 1'b1; wq(Q);
        ack = !sda_line; wq(Q);
        host_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        host_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); host_scl = 1'b1; wq(Q);
            b[i] = sda_line; wq(Q);
            host_scl = 1'b0; wq(Q);
        end
        host_sda = nack; wq(Q);
        host_scl = 1'b1; wq(2*Q);
        host_scl = 1'b0; wq(Q);
        host_sda = 1'b1;
    endtask

    task automatic settle();
        wq(10); quiet = 1'b1; wq(10);
    endtask

    // write data bytes; model updates for complete bytes only
    task automatic do_write(input logic [7:0] d [], input string tag);
        logic ack;
        bus_start();
        send_byte(8'hD2, ack); chk({tag, " R1 write addr ack"}, ack, 1);
        send_byte(8'h5A, ack); chk({tag, " R2 command ack"}, ack, 1);
        send_byte(8'h02, ack); chk({tag, " R2 count ack"}, ack, 1);
        foreach (d[i]) begin
            send_byte(d[i], ack);
            chk({tag, (i > 5) ? " R9 past-end ack" : " R2 data ack"}, ack, 1);
            if (i < 6) m_reg[i] = d[i];
        end
        bus_stop();
        settle();
    endtask

    task automatic do_read(input int extra, input string tag);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, ack); chk({tag, " R1 read addr ack"}, ack, 1);
        recv_byte(1'b0, b); chk({tag, " R4 count"}, b, 8'h06);
        for (int i = 0; i < 6; i++) begin
            recv_byte((extra == 0) && (i == 5), b);
            chk({tag, " R4 byte"}, b, m_reg[i]);
        end
        for (int i = 0; i < extra; i++) begin
            recv_byte(i == extra - 1, b);
            chk({tag, " R4 past end"}, b, 8'hFF);
        end
        wq(4);
        chk({tag, " R4 off bus after nack"}, sda_oe, 0);
        bus_stop();
        settle();
    endtask

    initial begin
        logic ack;
        m_reg[0] = 8'h10;
        for (int i = 1; i < 6; i++) m_reg[i] = 8'hFF;
        m_strap = 3'b101; m_mode = 1'b1;
        wq(5);
        rst_n = 1'b1;
        wq(3);
        quiet = 1'b1;
        wq(2);
        chk("R5 byte0 default freq from strap", freq_code, 3'b101);
        chk("R5 enables default", out_en, 40'hFF_FFFF_FFFF);
        chk("R5 spread off", spread_en, 0);
        chk("R8 mode captured", mode_latched, 1);

        strap_fs = 3'b010; strap_mode = 1'b0; wq(20);
        chk("R8 straps frozen", freq_code, 3'b101);
        chk("R8 mode frozen", mode_latched, 1);

        do_read(1, "reset readback");

        bus_start();
        send_byte(8'hA4, ack); chk("R1 foreign addr no ack", ack, 0);
        send_byte(8'h00, ack); chk("R1 ignored after foreign addr", ack, 0);
        bus_stop(); settle();

        do_write('{8'h8A, 8'h0F, 8'hF0}, "short");
        chk("R6 override code", freq_code, 3'b000);
        chk("R7 spread profile down", spread_prof, 2'b10);
        chk("R7 spread enable", spread_en, 1);
        chk("R3 later bytes untouched", out_en[39:16], 24'hFF_FFFF);
        do_read(0, "after short");

        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_bits(8'h00, 4);
        bus_stop(); settle();
        chk("R3 partial byte dropped", out_en[7:0], 8'h0F);

        do_write('{8'h01, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77}, "long");
        chk("R7 tristate", out_tristate, 1);
        chk("R6 strap source", freq_code, 3'b101);
        chk("R9 past end no effect", out_en, 40'h55_4433_2211);
        do_read(2, "after long");

        do_write('{8'h7C}, "byte0 only");
        chk("R6 code from bits 6:4", freq_code, 3'b111);
        chk("R7 profile 01", spread_prof, 2'b01);
        chk("R7 tristate cleared", out_tristate, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule